// File: doc/BRIEF.md
# MII Carrier and Collision Status Generator

This block drives the carrier-sense and collision status lines of a 10/100 Ethernet PHY's media-independent interface. It also registers the receive-side MII outputs. The datapath supplies receive- and transmit-activity strobes and a raw collision flag. The mode inputs select speed, duplex, loopback and repeater operation. From these the block decides, each clock, whether carrier and collision are reported to the MAC.

In half duplex at 10 Mbps, an optional SQE heartbeat can be enabled. When it is, the collision line is held high for a fixed window after each transmission ends. The window length is a parameter, in clock cycles, that sets roughly 1 ms: 25,000 cycles of a 25 MHz clock.

On the receive side, the data-valid, data nibble and error outputs are registered here. They are given per-signal output enables, controlled by a receive-enable input. When either symbol-bypass mode is selected, the error output is reused as the fifth bit of the raw 5-bit symbol.

Top module: `mii_status_gen`

## Requirements
- R1: While rst_n is low, crs, col, rx_dv, rx_er and every output enable are 0.
- R2: When none of full_dup, loopback and repeater is set, crs equals rx_act OR tx_act, one clock after those inputs are sampled. This holds at both speeds.
- R3: When any of full_dup, loopback or repeater is set, crs equals rx_act one clock after sampling, and tx_act has no effect on it.
- R4: In half duplex (full_dup = 0), at either speed, col is 1 one clock after col_raw is sampled high.
- R5: With full_dup = 1, col is 0 at all times, whatever col_raw, tx_act and hb_en do.
- R6: With spd_100 = 0, full_dup = 0 and hb_en = 1, a tx_act sample of 0 that follows a sample of 1 raises col at that clock. col then stays high for exactly HB_CYCLES clocks.
- R7: No heartbeat is produced when spd_100 = 1 or hb_en = 0. In that case col follows only col_raw.
- R8: A tx_act sample of 1 while a heartbeat is running ends it at that same clock. From then on col follows only col_raw.
- R9: When neither byp_code nor byp_align is set, rx_er equals spd_100 AND rx_dv_in AND sym_err, one clock after sampling.
- R10: When byp_code or byp_align is set, rx_er equals sym_b4, one clock after sampling.
- R11: rxd_oe (all bits), rxdv_oe, rxer_oe and rxclk_oe equal rx_en, one clock after sampling.
- R12: rx_dv and rxd equal rx_dv_in and rxd_in, one clock after sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_act | input | 1 | Receive activity from the datapath |
| tx_act | input | 1 | Transmit activity from the datapath |
| col_raw | input | 1 | Raw collision detection |
| spd_100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| full_dup | input | 1 | Full duplex selected |
| loopback | input | 1 | Loopback selected |
| repeater | input | 1 | Repeater operation selected |
| hb_en | input | 1 | SQE heartbeat enable |
| rx_en | input | 1 | Receive output enable request |
| byp_code | input | 1 | 4B5B coding bypass |
| byp_align | input | 1 | Symbol alignment bypass |
| rx_dv_in | input | 1 | Receive data valid from the datapath |
| rxd_in | input | DATA_W | Receive nibble from the datapath |
| sym_err | input | 1 | Invalid symbol flag |
| sym_b4 | input | 1 | Fifth bit of the raw symbol |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |
| rx_dv | output | 1 | Registered receive data valid |
| rxd | output | DATA_W | Registered receive nibble |
| rx_er | output | 1 | Receive error, or fifth symbol bit in bypass |
| rxd_oe | output | DATA_W | Output enables for rxd |
| rxdv_oe | output | 1 | Output enable for rx_dv |
| rxer_oe | output | 1 | Output enable for rx_er |
| rxclk_oe | output | 1 | Output enable for the receive clock pin |

## Verification
Every output is a single register stage away from the inputs. Carrier, collision, the error bit, the data path and the enables all change at the first rising edge that samples a new stimulus. The heartbeat window opens at the edge that samples tx_act falling and lasts HB_CYCLES edges. The bench drives inputs on the falling edge and pushes, for each cycle, the outputs expected after the next rising edge. A monitor pops and compares that entry just after that rising edge. Heartbeat length and cancellation are thus checked cycle by cycle against an independent countdown in the bench.

// File: rtl/mii_status_pkg.sv
package mii_status_pkg;

  // Which activity strobes feed carrier sense
  typedef enum logic {
    CRS_RX_OR_TX = 1'b0,
    CRS_RX_ONLY  = 1'b1
  } crs_src_e;

  // Counter width large enough to hold the value n
  function automatic int unsigned cnt_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((n >> w) != 0) w++;
    return w;
  endfunction

endpackage

// File: rtl/mii_crs_gen.sv
module mii_crs_gen
  import mii_status_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rx_act,
  input  logic     tx_act,
  input  crs_src_e src,
  output logic     crs
);

  logic crs_q, crs_d;

  always_comb begin
    unique case (src)
      CRS_RX_ONLY:  crs_d = rx_act;
      default:      crs_d = rx_act | tx_act;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crs_q <= 1'b0;
    else        crs_q <= crs_d;
  end

  assign crs = crs_q;

endmodule

// File: rtl/mii_col_hb.sv
module mii_col_hb
  import mii_status_pkg::*;
#(
  parameter int unsigned HB_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_act,
  input  logic col_raw,
  input  logic spd_100,
  input  logic full_dup,
  input  logic hb_en,
  output logic col
);

  localparam int unsigned CNT_W = cnt_width(HB_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HB_CYCLES);

  logic             tx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             col_q, col_d;
  logic             hb_ok, tx_fall, cnt_en;

  // Heartbeat allowed only at 10 Mbps half duplex when enabled
  assign hb_ok   = ~spd_100 & ~full_dup & hb_en;
  assign tx_fall = tx_d & ~tx_act;

  always_comb begin
    cnt_d = cnt_q;
    if (tx_act || !hb_ok)
      cnt_d = '0;
    else if (tx_fall)
      cnt_d = CNT_LOAD;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  assign cnt_en = (cnt_d != cnt_q);

  // Collision uses the next counter value so a cancel takes effect at once
  always_comb begin
    col_d = ~full_dup & (col_raw | (cnt_d != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_d  <= 1'b0;
      col_q <= 1'b0;
    end else begin
      tx_d  <= tx_act;
      col_q <= col_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign col = col_q;

endmodule

// File: rtl/mii_rx_stage.sv
module mii_rx_stage #(
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              bypass,
  input  logic              spd_100,
  input  logic              rx_dv_in,
  input  logic [DATA_W-1:0] rxd_in,
  input  logic              sym_err,
  input  logic              sym_b4,
  output logic              rx_dv,
  output logic [DATA_W-1:0] rxd,
  output logic              rx_er,
  output logic [DATA_W-1:0] rxd_oe,
  output logic              rxdv_oe,
  output logic              rxer_oe,
  output logic              rxclk_oe
);

  logic              dv_q, er_q, er_d;
  logic [DATA_W-1:0] rxd_q;
  logic              ctl_oe_q;

  always_comb begin
    if (bypass) er_d = sym_b4;
    else        er_d = spd_100 & rx_dv_in & sym_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q     <= 1'b0;
      er_q     <= 1'b0;
      rxd_q    <= '0;
      ctl_oe_q <= 1'b0;
    end else begin
      dv_q     <= rx_dv_in;
      er_q     <= er_d;
      rxd_q    <= rxd_in;
      ctl_oe_q <= rx_en;
    end
  end

  // One enable flop per data pin
  for (genvar i = 0; i < DATA_W; i++) begin : g_data_oe
    logic oe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= rx_en;
    end
    assign rxd_oe[i] = oe_q;
  end

  assign rx_dv    = dv_q;
  assign rx_er    = er_q;
  assign rxd      = rxd_q;
  assign rxdv_oe  = ctl_oe_q;
  assign rxer_oe  = ctl_oe_q;
  assign rxclk_oe = ctl_oe_q;

endmodule

// File: rtl/mii_status_gen.sv
module mii_status_gen
  import mii_status_pkg::*;
#(
  parameter int unsigned DATA_W    = 4,
  parameter int unsigned HB_CYCLES = 25000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_act,
  input  logic              tx_act,
  input  logic              col_raw,
  input  logic              spd_100,
  input  logic              full_dup,
  input  logic              loopback,
  input  logic              repeater,
  input  logic              hb_en,
  input  logic              rx_en,
  input  logic              byp_code,
  input  logic              byp_align,
  input  logic              rx_dv_in,
  input  logic [DATA_W-1:0] rxd_in,
  input  logic              sym_err,
  input  logic              sym_b4,
  output logic              crs,
  output logic              col,
  output logic              rx_dv,
  output logic [DATA_W-1:0] rxd,
  output logic              rx_er,
  output logic [DATA_W-1:0] rxd_oe,
  output logic              rxdv_oe,
  output logic              rxer_oe,
  output logic              rxclk_oe
);

  crs_src_e crs_src;
  logic     bypass;

  assign crs_src = (full_dup | loopback | repeater) ? CRS_RX_ONLY : CRS_RX_OR_TX;
  assign bypass  = byp_code | byp_align;

  mii_crs_gen u_crs (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_act (rx_act),
    .tx_act (tx_act),
    .src    (crs_src),
    .crs    (crs)
  );

  mii_col_hb #(.HB_CYCLES(HB_CYCLES)) u_col (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_act   (tx_act),
    .col_raw  (col_raw),
    .spd_100  (spd_100),
    .full_dup (full_dup),
    .hb_en    (hb_en),
    .col      (col)
  );

  mii_rx_stage #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .bypass   (bypass),
    .spd_100  (spd_100),
    .rx_dv_in (rx_dv_in),
    .rxd_in   (rxd_in),
    .sym_err  (sym_err),
    .sym_b4   (sym_b4),
    .rx_dv    (rx_dv),
    .rxd      (rxd),
    .rx_er    (rx_er),
    .rxd_oe   (rxd_oe),
    .rxdv_oe  (rxdv_oe),
    .rxer_oe  (rxer_oe),
    .rxclk_oe (rxclk_oe)
  );

endmodule

// File: rtl/mii_status_chk.sv
module mii_status_chk #(
  parameter int unsigned DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_act,
  input logic              tx_act,
  input logic              col_raw,
  input logic              spd_100,
  input logic              full_dup,
  input logic              loopback,
  input logic              repeater,
  input logic              hb_en,
  input logic              rx_en,
  input logic              byp_code,
  input logic              byp_align,
  input logic              rx_dv_in,
  input logic              sym_b4,
  input logic              crs,
  input logic              col,
  input logic              rx_er,
  input logic [DATA_W-1:0] rxd_oe,
  input logic              rxdv_oe
);

  always_comb begin
    if (!rst_n) begin
      a_reset_r1: assert (!crs && !col && !rx_er && !rxdv_oe && rxd_oe == '0);
    end
  end

  p_crs_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_dup && !loopback && !repeater && (rx_act || tx_act)) |=> crs);

  p_crs_rxonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((full_dup || loopback || repeater) && !rx_act) |=> !crs);

  p_col_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_dup && col_raw) |=> col);

  p_no_col_fd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full_dup |=> !col);

  p_no_hb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((spd_100 || !hb_en) && !col_raw) |=> !col);

  p_hb_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_act && !col_raw) |=> !col);

  p_bypass_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_code || byp_align) |=> (rx_er == $past(sym_b4)));

  p_oe_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rxdv_oe && rxd_oe == '0));

  p_er_dv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp_code && !byp_align && !rx_dv_in) |=> !rx_er);

endmodule

bind mii_status_gen mii_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_act    (rx_act),
  .tx_act    (tx_act),
  .col_raw   (col_raw),
  .spd_100   (spd_100),
  .full_dup  (full_dup),
  .loopback  (loopback),
  .repeater  (repeater),
  .hb_en     (hb_en),
  .rx_en     (rx_en),
  .byp_code  (byp_code),
  .byp_align (byp_align),
  .rx_dv_in  (rx_dv_in),
  .sym_b4    (sym_b4),
  .crs       (crs),
  .col       (col),
  .rx_er     (rx_er),
  .rxd_oe    (rxd_oe),
  .rxdv_oe   (rxdv_oe)
);

// File: tb/sim_mii_status_gen.sv
`timescale 1ns/1ps
module sim_mii_status_gen;

  localparam int DW = 4;
  localparam int HB = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_act, tx_act, col_raw, spd_100, full_dup, loopback, repeater, hb_en;
  logic rx_en, byp_code, byp_align, rx_dv_in, sym_err, sym_b4;
  logic [DW-1:0] rxd_in;
  logic crs, col, rx_dv, rx_er, rxdv_oe, rxer_oe, rxclk_oe;
  logic [DW-1:0] rxd, rxd_oe;

  always #2 clk = ~clk;

  mii_status_gen #(.DATA_W(DW), .HB_CYCLES(HB)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_act(rx_act), .tx_act(tx_act), .col_raw(col_raw),
    .spd_100(spd_100), .full_dup(full_dup), .loopback(loopback), .repeater(repeater),
    .hb_en(hb_en), .rx_en(rx_en), .byp_code(byp_code), .byp_align(byp_align),
    .rx_dv_in(rx_dv_in), .rxd_in(rxd_in), .sym_err(sym_err), .sym_b4(sym_b4),
    .crs(crs), .col(col), .rx_dv(rx_dv), .rxd(rxd), .rx_er(rx_er),
    .rxd_oe(rxd_oe), .rxdv_oe(rxdv_oe), .rxer_oe(rxer_oe), .rxclk_oe(rxclk_oe)
  );

  typedef struct {
    logic          crs, col, dv, er, oe;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  exp_t q[$];
  int compared = 0;
  int mismatched = 0;
  logic prev_tx = 1'b0;
  int hb_left = 0;

  // Driver side: build the expectation for the coming rising edge
  task automatic push(input string tag);
    exp_t e;
    logic ok;
    ok = !spd_100 && !full_dup && hb_en;
    if (tx_act || !ok)     hb_left = 0;
    else if (prev_tx)      hb_left = HB;
    else if (hb_left > 0)  hb_left--;
    prev_tx = tx_act;
    e.crs = (full_dup || loopback || repeater) ? rx_act : (rx_act || tx_act);
    e.col = !full_dup && (col_raw || hb_left > 0);
    e.dv  = rx_dv_in;
    e.d   = rxd_in;
    e.er  = (byp_code || byp_align) ? sym_b4 : (spd_100 && rx_dv_in && sym_err);
    e.oe  = rx_en;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(input string tag);
    push(tag);
    @(negedge clk);
  endtask

  // Monitor side
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      logic [DW+DW+7:0] act_v, exp_v;
      e = q.pop_front();
      act_v = {crs, col, rx_dv, rx_er, rxdv_oe, rxer_oe, rxclk_oe, rxd_oe, rxd, 1'b0};
      exp_v = {e.crs, e.col, e.dv, e.er, e.oe, e.oe, e.oe, {DW{e.oe}}, e.d, 1'b0};
      compared++;
      if (act_v !== exp_v) begin
        mismatched++;
        $display("FAIL %s: {crs,col,dv,er,oe*,rxd} actual %b expected %b", e.tag, act_v, exp_v);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {rx_act, tx_act, col_raw, spd_100, full_dup, loopback, repeater, hb_en} = '0;
    {rx_en, byp_code, byp_align, rx_dv_in, sym_err, sym_b4} = '0;
    rxd_in = '0;
    rx_en = 1'b1; rx_dv_in = 1'b1; rx_act = 1'b1; col_raw = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs low during reset despite active inputs
    compared++;
    if ({crs, col, rx_dv, rx_er, rxdv_oe, rxer_oe, rxclk_oe, rxd_oe} !== '0) begin
      mismatched++;
      $display("FAIL R1: actual %b expected 0", {crs, col, rx_dv, rx_er, rxdv_oe, rxer_oe, rxclk_oe, rxd_oe});
    end
    rst_n = 1'b1;
    {rx_act, col_raw} = '0;

    // R2: half duplex, both speeds
    for (int s = 0; s < 2; s++) begin
      spd_100 = s[0];
      for (int p = 0; p < 4; p++) begin
        rx_act = p[0]; tx_act = p[1];
        tick("R2");
      end
    end
    // R4: collision at both speeds in half duplex
    tx_act = 1'b0; rx_act = 1'b0;
    for (int s = 0; s < 2; s++) begin
      spd_100 = s[0]; col_raw = 1'b1; tick("R4");
      col_raw = 1'b0; tick("R4");
    end

    // R3: rx-only carrier in full duplex, loopback, repeater
    for (int m = 0; m < 3; m++) begin
      full_dup = (m == 0); loopback = (m == 1); repeater = (m == 2);
      for (int p = 0; p < 4; p++) begin
        rx_act = p[0]; tx_act = p[1];
        tick("R3");
      end
    end
    loopback = 1'b0; repeater = 1'b0; rx_act = 1'b0;

    // R5: full duplex never raises col, even with 10M heartbeat set
    full_dup = 1'b1; spd_100 = 1'b0; hb_en = 1'b1; col_raw = 1'b1;
    tx_act = 1'b1; tick("R5"); tick("R5");
    tx_act = 1'b0;
    for (int i = 0; i < 5; i++) tick("R5");
    col_raw = 1'b0;
    for (int i = 0; i < 5; i++) tick("R5");
    full_dup = 1'b0;

    // R6: heartbeat window after transmit ends at 10M half duplex
    tx_act = 1'b1; tick("R6"); tick("R6"); tick("R6");
    tx_act = 1'b0;
    for (int i = 0; i < HB + 4; i++) tick("R6");

    // R7: no heartbeat at 100M, nor with enable clear
    spd_100 = 1'b1;
    tx_act = 1'b1; tick("R7"); tx_act = 1'b0;
    for (int i = 0; i < 6; i++) tick("R7");
    spd_100 = 1'b0; hb_en = 1'b0;
    tx_act = 1'b1; tick("R7"); tx_act = 1'b0;
    for (int i = 0; i < 6; i++) tick("R7");
    hb_en = 1'b1;

    // R8: new transmission cancels a running heartbeat
    tx_act = 1'b1; tick("R8"); tx_act = 1'b0;
    for (int i = 0; i < 5; i++) tick("R8");
    tx_act = 1'b1;
    for (int i = 0; i < 3; i++) tick("R8");
    col_raw = 1'b1; tick("R8"); col_raw = 1'b0; tick("R8");
    tx_act = 1'b1; tick("R8"); tx_act = 1'b0; tick("R8"); tick("R8");
    hb_en = 1'b0; tick("R8"); tick("R8");

    // R9: error flag in normal mode, R12: data pass
    for (int s = 0; s < 2; s++) begin
      spd_100 = s[0];
      for (int p = 0; p < 4; p++) begin
        rx_dv_in = p[0]; sym_err = p[1]; rxd_in = DW'(p * 5 + s * 3 + 1);
        tick("R9");
      end
    end
    for (int p = 0; p < 6; p++) begin
      rx_dv_in = p[0]; rxd_in = DW'(p * 7 + 2); tick("R12");
    end

    // R10: fifth symbol bit in either bypass mode
    spd_100 = 1'b1; rx_dv_in = 1'b1; sym_err = 1'b1;
    for (int m = 0; m < 2; m++) begin
      byp_code = (m == 0); byp_align = (m == 1);
      sym_b4 = 1'b0; tick("R10");
      sym_b4 = 1'b1; sym_err = 1'b0; tick("R10");
      sym_err = 1'b1;
    end
    byp_code = 1'b0; byp_align = 1'b0; sym_b4 = 1'b0;

    // R11: output enables follow the receive enable
    rx_en = 1'b0; tick("R11"); tick("R11");
    rx_en = 1'b1; tick("R11");
    rx_en = 1'b0; tick("R11");
    rx_en = 1'b1; tick("R11");

    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule